// File: doc/BRIEF.md
# Raster Display Timing Generator

This block paces a progressive raster display. It runs a pixel-column counter and a line counter over a frame whose total width and height come from configuration inputs. It drives horizontal sync, vertical sync, horizontal blanking, vertical blanking, a field indicator and a data-enable strobe. Each position comes from its own configuration input. Vertical sync and vertical blanking do not switch at a line boundary. They switch at an exact (column, line) point, so a vertical pulse can begin part way along a line. The pixel output carries the incoming pixel word while data enable is high. At every blanked position it carries a configurable default word instead.

The block has two pacing modes. In free-running mode the counters wrap on their own at the configured frame size. In follower mode, rising edges on external horizontal and vertical sync inputs restart the pixel and line counters. When those inputs stop toggling, the counters stall at the last column and the last line rather than starting new lines and frames on their own. All configuration is captured into a shadow copy only when the counters enter position (0,0). A write in the middle of a frame therefore changes the following frame and never tears the current one.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is low at a clock edge, every output is 0 after that edge, and counting restarts at column 0, line 0 once reset is released.
- R2: In free-running mode (mode input 0), the column counter steps by one every clock and wraps from frame width minus 1 to 0. The line counter steps on that wrap and itself wraps from frame height minus 1 to 0, giving an hsync period of exactly frame-width clocks.
- R3: Horizontal sync is set one clock after the column counter equals the sync-on column and cleared one clock after it equals the sync-off column. If both columns are equal, set wins.
- R4: Vertical sync is set one clock after the counters equal the on point (column and line both matching) and cleared one clock after they equal the off point, with set winning.
- R5: Horizontal blanking follows the R3 rule with its own on and off columns. Vertical blanking follows the R4 rule with its own on and off points.
- R6: Data enable is high one clock after a position that lies inside the active window (x from offset to offset+width-1, y likewise) and for which neither blanking flag is set on that same edge. It is never high while either blanking output is high.
- R7: The pixel output equals the pixel input from one clock earlier when data enable is high, and equals the shadowed default value otherwise.
- R8: In follower mode (mode input 1), each external sync input passes through two synchronising flops. A rising edge of the synchronised horizontal sync sets the column to 0 and advances the line by one, saturating at frame height minus 1. A rising edge of the synchronised vertical sync sets the line to 0. The column reacts on the third clock edge after the input is sampled high.
- R9: In follower mode, with no new horizontal sync edge, the column counter holds at frame width minus 1, so all horizontal outputs stop changing.
- R10: The field output is 0 after any clock edge taken in free-running mode. In follower mode it equals the external field input as sampled three clock edges earlier.
- R11: Configuration inputs are captured only on the edge at which the counters enter (0,0), or during reset. Changes at any other time first act on the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | 0 free-running, 1 follow external syncs |
| ext_hsync | input | 1 | Asynchronous external horizontal sync |
| ext_vsync | input | 1 | Asynchronous external vertical sync |
| ext_field | input | 1 | Asynchronous external field flag |
| cfg_frame_w | input | CW | Total pixels per line |
| cfg_frame_h | input | CW | Total lines per frame |
| cfg_win_x | input | CW | Active window first column |
| cfg_win_y | input | CW | Active window first line |
| cfg_win_w | input | CW | Active window width |
| cfg_win_h | input | CW | Active window height |
| cfg_hblk_on | input | CW | Column where horizontal blanking sets |
| cfg_hblk_off | input | CW | Column where horizontal blanking clears |
| cfg_hs_on | input | CW | Column where horizontal sync sets |
| cfg_hs_off | input | CW | Column where horizontal sync clears |
| cfg_vblk_on_x | input | CW | Vertical blanking set column |
| cfg_vblk_on_y | input | CW | Vertical blanking set line |
| cfg_vblk_off_x | input | CW | Vertical blanking clear column |
| cfg_vblk_off_y | input | CW | Vertical blanking clear line |
| cfg_vs_on_x | input | CW | Vertical sync set column |
| cfg_vs_on_y | input | CW | Vertical sync set line |
| cfg_vs_off_x | input | CW | Vertical sync clear column |
| cfg_vs_off_y | input | CW | Vertical sync clear line |
| cfg_default | input | PW | Pixel word sent at blanked positions |
| pix_in | input | PW | Incoming pixel word |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| field_o | output | 1 | Field indicator |
| de_o | output | 1 | Active data enable |
| pix_o | output | PW | Outgoing pixel word |

## Verification
The hardest state to reach from the ports is follower mode, with the counters stalled at the last column and held there while configuration writes wait in the shadow path. The stimulus drives external sync pulses with random line lengths, both shorter and longer than the frame width, so lines are cut short as well as stretched into a stall. It then holds both syncs low for several frame widths and checks that no horizontal output moves. It also rewrites the configuration at random mid-frame moments and sets sync-on equal to sync-off to exercise set priority.

// File: rtl/rtg_pkg.sv
// Shared widths and the configuration record of the raster timing generator.
// Assumes every coordinate fits in CW bits and frame width/height are >= 1.
package rtg_pkg;
    parameter int CW = 12;
    parameter int PW = 16;

    typedef logic [CW-1:0] coord_t;

    typedef struct packed {
        coord_t fw;
        coord_t fh;
        coord_t ax;
        coord_t ay;
        coord_t aw;
        coord_t ah;
        coord_t hb_on;
        coord_t hb_off;
        coord_t hs_on;
        coord_t hs_off;
        coord_t vb_on_x;
        coord_t vb_on_y;
        coord_t vb_off_x;
        coord_t vb_off_y;
        coord_t vs_on_x;
        coord_t vs_on_y;
        coord_t vs_off_x;
        coord_t vs_off_y;
        logic [PW-1:0] defv;
    } cfg_t;

    // Index of each set/reset timing flag.
    localparam int F_HS   = 0;
    localparam int F_HB   = 1;
    localparam int F_VS   = 2;
    localparam int F_VB   = 3;
    localparam int NFLAGS = 4;

    // Index of each synchronised external input.
    localparam int S_H  = 0;
    localparam int S_V  = 1;
    localparam int S_F  = 2;
    localparam int NSYN = 3;
endpackage

// File: rtl/rtg_sync.sv
// Multi-bit synchroniser with rising-edge detect on the synchronised level.
// Assumes each bit is an independent asynchronous level; STAGES >= 2.
module rtg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [STAGES:0][W-1:0] chain;

    // Shift the inputs through the flop chain, one extra stage for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], async_in};
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/rtg_counter.sv
// Pixel/line position counters with frame-start configuration shadow.
// Free-running mode wraps at the shadowed frame size; follower mode is paced
// by synchronised sync edges and stalls at the last column / line.
module rtg_counter
    import rtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ext_mode,
    input  logic   hs_rise,
    input  logic   vs_rise,
    input  cfg_t   cfg_in,
    output coord_t px,
    output coord_t ln,
    output cfg_t   sh
);
    coord_t px_n, ln_n;
    logic   last_px, last_ln, frame_start;

    // Next position for both pacing modes.
    always_comb begin
        last_px = (px == sh.fw - coord_t'(1));
        last_ln = (ln == sh.fh - coord_t'(1));
        if (!ext_mode) begin
            px_n = last_px ? '0 : px + coord_t'(1);
            ln_n = last_px ? (last_ln ? '0 : ln + coord_t'(1)) : ln;
        end else begin
            px_n = hs_rise ? '0 : (last_px ? px : px + coord_t'(1));
            ln_n = vs_rise ? '0 :
                   (hs_rise ? (last_ln ? ln : ln + coord_t'(1)) : ln);
        end
        frame_start = (px_n == '0) && (ln_n == '0);
    end

    // Advance counters; capture configuration on entry to (0,0).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px <= '0;
            ln <= '0;
            sh <= cfg_in;
        end else begin
            px <= px_n;
            ln <= ln_n;
            if (frame_start) sh <= cfg_in;
        end
    end
endmodule

// File: rtl/rtg_flag.sv
// Set/reset timing flag: set on a set hit, cleared on a clear hit, set wins.
// Exposes the next value so dependent outputs stay cycle-aligned.
module rtg_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_hit,
    input  logic clr_hit,
    output logic q,
    output logic q_n
);
    // Next state with set priority.
    always_comb q_n = set_hit ? 1'b1 : (clr_hit ? 1'b0 : q);

    // Hold the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_n;
    end
endmodule

// File: rtl/raster_timing_gen.sv
// Raster display timing generator: counters, window decode and registered
// sync/blank/enable/pixel outputs. Assumes configuration values lie within
// the frame and that the frame is at least one pixel wide and one line tall.
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_mode,
    input  logic          ext_hsync,
    input  logic          ext_vsync,
    input  logic          ext_field,
    input  logic [CW-1:0] cfg_frame_w,
    input  logic [CW-1:0] cfg_frame_h,
    input  logic [CW-1:0] cfg_win_x,
    input  logic [CW-1:0] cfg_win_y,
    input  logic [CW-1:0] cfg_win_w,
    input  logic [CW-1:0] cfg_win_h,
    input  logic [CW-1:0] cfg_hblk_on,
    input  logic [CW-1:0] cfg_hblk_off,
    input  logic [CW-1:0] cfg_hs_on,
    input  logic [CW-1:0] cfg_hs_off,
    input  logic [CW-1:0] cfg_vblk_on_x,
    input  logic [CW-1:0] cfg_vblk_on_y,
    input  logic [CW-1:0] cfg_vblk_off_x,
    input  logic [CW-1:0] cfg_vblk_off_y,
    input  logic [CW-1:0] cfg_vs_on_x,
    input  logic [CW-1:0] cfg_vs_on_y,
    input  logic [CW-1:0] cfg_vs_off_x,
    input  logic [CW-1:0] cfg_vs_off_y,
    input  logic [PW-1:0] cfg_default,
    input  logic [PW-1:0] pix_in,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          hblank_o,
    output logic          vblank_o,
    output logic          field_o,
    output logic          de_o,
    output logic [PW-1:0] pix_o
);
    cfg_t                cfg_live, shadow;
    coord_t              px_q, ln_q;
    logic [NSYN-1:0]     syn_lvl, syn_rise;
    logic [NFLAGS-1:0]   set_hit, clr_hit, flag_q, flag_n;
    logic [CW:0]         win_x_end, win_y_end;
    logic                in_win, de_n;
    logic                de_q, field_q;
    logic [PW-1:0]       pix_q;

    // Gather the configuration inputs into one record.
    always_comb begin
        cfg_live.fw       = cfg_frame_w;
        cfg_live.fh       = cfg_frame_h;
        cfg_live.ax       = cfg_win_x;
        cfg_live.ay       = cfg_win_y;
        cfg_live.aw       = cfg_win_w;
        cfg_live.ah       = cfg_win_h;
        cfg_live.hb_on    = cfg_hblk_on;
        cfg_live.hb_off   = cfg_hblk_off;
        cfg_live.hs_on    = cfg_hs_on;
        cfg_live.hs_off   = cfg_hs_off;
        cfg_live.vb_on_x  = cfg_vblk_on_x;
        cfg_live.vb_on_y  = cfg_vblk_on_y;
        cfg_live.vb_off_x = cfg_vblk_off_x;
        cfg_live.vb_off_y = cfg_vblk_off_y;
        cfg_live.vs_on_x  = cfg_vs_on_x;
        cfg_live.vs_on_y  = cfg_vs_on_y;
        cfg_live.vs_off_x = cfg_vs_off_x;
        cfg_live.vs_off_y = cfg_vs_off_y;
        cfg_live.defv     = cfg_default;
    end

    rtg_sync #(.W(NSYN), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ext_field, ext_vsync, ext_hsync}),
        .lvl      (syn_lvl),
        .rise     (syn_rise)
    );

    rtg_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_mode (ext_mode),
        .hs_rise  (syn_rise[S_H]),
        .vs_rise  (syn_rise[S_V]),
        .cfg_in   (cfg_live),
        .px       (px_q),
        .ln       (ln_q),
        .sh       (shadow)
    );

    // Position hits for each flag; vertical ones need column and line.
    always_comb begin
        set_hit[F_HS] = (px_q == shadow.hs_on);
        clr_hit[F_HS] = (px_q == shadow.hs_off);
        set_hit[F_HB] = (px_q == shadow.hb_on);
        clr_hit[F_HB] = (px_q == shadow.hb_off);
        set_hit[F_VS] = (px_q == shadow.vs_on_x)  && (ln_q == shadow.vs_on_y);
        clr_hit[F_VS] = (px_q == shadow.vs_off_x) && (ln_q == shadow.vs_off_y);
        set_hit[F_VB] = (px_q == shadow.vb_on_x)  && (ln_q == shadow.vb_on_y);
        clr_hit[F_VB] = (px_q == shadow.vb_off_x) && (ln_q == shadow.vb_off_y);
    end

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        rtg_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_hit (set_hit[i]),
            .clr_hit (clr_hit[i]),
            .q       (flag_q[i]),
            .q_n     (flag_n[i])
        );
    end

    // Active window membership and enable using this edge's blanking state.
    always_comb begin
        win_x_end = {1'b0, shadow.ax} + {1'b0, shadow.aw};
        win_y_end = {1'b0, shadow.ay} + {1'b0, shadow.ah};
        in_win    = (px_q >= shadow.ax) && ({1'b0, px_q} < win_x_end) &&
                    (ln_q >= shadow.ay) && ({1'b0, ln_q} < win_y_end);
        de_n      = in_win && !flag_n[F_HB] && !flag_n[F_VB];
    end

    // Register enable, pixel word and field output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q    <= 1'b0;
            pix_q   <= '0;
            field_q <= 1'b0;
        end else begin
            de_q    <= de_n;
            pix_q   <= de_n ? pix_in : shadow.defv;
            field_q <= ext_mode & syn_lvl[S_F];
        end
    end

    assign hsync_o  = flag_q[F_HS];
    assign hblank_o = flag_q[F_HB];
    assign vsync_o  = flag_q[F_VS];
    assign vblank_o = flag_q[F_VB];
    assign de_o     = de_q;
    assign pix_o    = pix_q;
    assign field_o  = field_q;
endmodule

// File: rtl/rtg_checker.sv
// Temporal checks on the raster timing generator, bound to every instance.
module rtg_checker
    import rtg_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   ext_mode,
    input logic   hs_rise,
    input logic   fld_lvl,
    input coord_t px,
    input coord_t sh_fw,
    input coord_t sh_hs_on,
    input logic   hsync,
    input logic   hblank,
    input logic   vblank,
    input logic   de,
    input logic   field
);
    // R2
    px_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        px < sh_fw);

    // R2
    px_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && px == sh_fw - coord_t'(1)) |=> px == '0);

    // R3
    hs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> $past(px) == $past(sh_hs_on));

    // R6
    de_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hblank && !vblank));

    // R8
    ext_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && hs_rise) |=> px == '0);

    // R9
    ext_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && !hs_rise && px == sh_fw - coord_t'(1)) |=> $stable(px));

    // R10
    field_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field == ($past(ext_mode) & $past(fld_lvl)));
endmodule

bind raster_timing_gen rtg_checker u_rtg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_mode (ext_mode),
    .hs_rise  (syn_rise[rtg_pkg::S_H]),
    .fld_lvl  (syn_lvl[rtg_pkg::S_F]),
    .px       (px_q),
    .sh_fw    (shadow.fw),
    .sh_hs_on (shadow.hs_on),
    .hsync    (hsync_o),
    .hblank   (hblank_o),
    .vblank   (vblank_o),
    .de       (de_o),
    .field    (field_o)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
    import rtg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_mode = 1'b0, ext_hsync = 1'b0, ext_vsync = 1'b0, ext_field = 1'b0;
    logic [PW-1:0] pix_in = '0;
    cfg_t cfg;
    logic hsync_o, vsync_o, hblank_o, vblank_o, field_o, de_o;
    logic [PW-1:0] pix_o;

    int errors = 0, checks = 0;
    bit finished = 0;
    string phase = "R1 reset";

    always #5 clk = ~clk;

    raster_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
        .ext_hsync(ext_hsync), .ext_vsync(ext_vsync), .ext_field(ext_field),
        .cfg_frame_w(cfg.fw), .cfg_frame_h(cfg.fh),
        .cfg_win_x(cfg.ax), .cfg_win_y(cfg.ay), .cfg_win_w(cfg.aw), .cfg_win_h(cfg.ah),
        .cfg_hblk_on(cfg.hb_on), .cfg_hblk_off(cfg.hb_off),
        .cfg_hs_on(cfg.hs_on), .cfg_hs_off(cfg.hs_off),
        .cfg_vblk_on_x(cfg.vb_on_x), .cfg_vblk_on_y(cfg.vb_on_y),
        .cfg_vblk_off_x(cfg.vb_off_x), .cfg_vblk_off_y(cfg.vb_off_y),
        .cfg_vs_on_x(cfg.vs_on_x), .cfg_vs_on_y(cfg.vs_on_y),
        .cfg_vs_off_x(cfg.vs_off_x), .cfg_vs_off_y(cfg.vs_off_y),
        .cfg_default(cfg.defv), .pix_in(pix_in),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .hblank_o(hblank_o),
        .vblank_o(vblank_o), .field_o(field_o), .de_o(de_o), .pix_o(pix_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
        end
    endtask

    function automatic cfg_t rand_cfg();
        cfg_t c;
        c.aw = coord_t'(8 + $urandom % 12);
        c.ah = coord_t'(4 + $urandom % 4);
        c.fw = c.aw + 30;
        c.fh = c.ah + 5;
        c.ax = coord_t'($urandom % 3);
        c.ay = '0;
        c.hb_on = c.aw;        c.hb_off = '0;
        c.hs_on = c.aw + 9;    c.hs_off = c.aw + 19;
        c.vs_on_x = c.aw;      c.vs_on_y = 1;
        c.vs_off_x = c.aw + 14; c.vs_off_y = 2;
        c.vb_on_x = '0;        c.vb_on_y = 1;
        c.vb_off_x = '0;       c.vb_off_y = 3;
        c.defv = PW'($urandom);
        return c;
    endfunction

    // Reference model built from the requirements.
    coord_t m_px, m_ln;
    cfg_t m_sh;
    logic m_hs, m_hb, m_vs, m_vb, m_de, m_fld, m_live;
    logic [PW-1:0] m_pix;
    logic [2:0] m_hc, m_vc;
    logic [1:0] m_fc;

    always @(posedge clk) begin
        logic hs_n, hb_n, vs_n, vb_n, de_n, hr, vr, inw;
        coord_t npx, nln;
        if (!rst_n) begin
            m_px = 0; m_ln = 0; m_sh = cfg;
            {m_hs, m_hb, m_vs, m_vb, m_de, m_fld, m_live} = '0;
            m_pix = '0; m_hc = '0; m_vc = '0; m_fc = '0;
        end else begin
            m_live = 1;
            hr = m_hc[1] & ~m_hc[2];
            vr = m_vc[1] & ~m_vc[2];
            hs_n = (m_px == m_sh.hs_on) ? 1'b1 : (m_px == m_sh.hs_off) ? 1'b0 : m_hs;
            hb_n = (m_px == m_sh.hb_on) ? 1'b1 : (m_px == m_sh.hb_off) ? 1'b0 : m_hb;
            vs_n = (m_px == m_sh.vs_on_x && m_ln == m_sh.vs_on_y) ? 1'b1 :
                   (m_px == m_sh.vs_off_x && m_ln == m_sh.vs_off_y) ? 1'b0 : m_vs;
            vb_n = (m_px == m_sh.vb_on_x && m_ln == m_sh.vb_on_y) ? 1'b1 :
                   (m_px == m_sh.vb_off_x && m_ln == m_sh.vb_off_y) ? 1'b0 : m_vb;
            inw = (int'(m_px) >= int'(m_sh.ax)) && (int'(m_px) < int'(m_sh.ax) + int'(m_sh.aw)) &&
                  (int'(m_ln) >= int'(m_sh.ay)) && (int'(m_ln) < int'(m_sh.ay) + int'(m_sh.ah));
            de_n = inw && !hb_n && !vb_n;
            m_pix = de_n ? pix_in : m_sh.defv;
            m_fld = ext_mode ? m_fc[1] : 1'b0;
            m_hs = hs_n; m_hb = hb_n; m_vs = vs_n; m_vb = vb_n; m_de = de_n;
            if (!ext_mode) begin
                if (int'(m_px) == int'(m_sh.fw) - 1) begin
                    npx = 0;
                    nln = (int'(m_ln) == int'(m_sh.fh) - 1) ? 0 : m_ln + 1;
                end else begin
                    npx = m_px + 1; nln = m_ln;
                end
            end else begin
                npx = hr ? 0 : ((int'(m_px) == int'(m_sh.fw) - 1) ? m_px : m_px + 1);
                nln = vr ? 0 : (hr ? ((int'(m_ln) == int'(m_sh.fh) - 1) ? m_ln : m_ln + 1) : m_ln);
            end
            m_px = npx; m_ln = nln;
            if (npx == 0 && nln == 0) m_sh = cfg;
            m_hc = {m_hc[1:0], ext_hsync};
            m_vc = {m_vc[1:0], ext_vsync};
            m_fc = {m_fc[0], ext_field};
        end
    end

    // Compare outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (m_live && !finished) begin
            chk("R3 hsync", hsync_o, m_hs);
            chk("R4 vsync", vsync_o, m_vs);
            chk("R5 hblank", hblank_o, m_hb);
            chk("R5 vblank", vblank_o, m_vb);
            chk("R6 de", de_o, m_de);
            chk("R7 pixel", pix_o, m_pix);
            chk("R10 field", field_o, m_fld);
        end
        pix_in <= PW'($urandom);
    end

    task automatic ext_line(input int len, input bit vpulse);
        ext_hsync = 1; ext_vsync = vpulse;
        repeat (2) @(negedge clk);
        ext_hsync = 0; ext_vsync = 0;
        repeat (len) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int rises;
        logic prev_hs;
        void'($urandom(32'd20240611));
        cfg = rand_cfg();
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 hsync", hsync_o, 0); chk("R1 vsync", vsync_o, 0);
        chk("R1 hblank", hblank_o, 0); chk("R1 vblank", vblank_o, 0);
        chk("R1 de", de_o, 0); chk("R1 pixel", pix_o, 0); chk("R1 field", field_o, 0);
        rst_n = 1;

        phase = "R2 free-run";
        ext_field = 1;
        repeat (3000) @(negedge clk);
        // R2 hsync period equals frame width
        begin
            int t0, t1;
            @(posedge hsync_o); t0 = $time;
            @(posedge hsync_o); t1 = $time;
            chk("R2 hsync period", (t1 - t0) / 10, cfg.fw);
        end

        phase = "R11 mid-frame write";
        for (int k = 0; k < 6; k++) begin
            repeat (100 + $urandom % 300) @(negedge clk);
            cfg = rand_cfg();
        end
        repeat (800) @(negedge clk);

        phase = "R3 set priority";
        cfg.hs_off = cfg.hs_on;
        repeat (3 * cfg.fw * cfg.fh) @(negedge clk);
        cfg = rand_cfg();
        repeat (1000) @(negedge clk);

        phase = "R8 follower";
        ext_mode = 1;
        for (int l = 0; l < 60; l++) begin
            ext_field = (l / 12) % 2;
            ext_line(int'(cfg.fw) - 12 + int'($urandom % 25), (l % 12) == 0);
        end

        phase = "R9 stall";
        repeat (2 * cfg.fw) @(negedge clk);
        rises = 0; prev_hs = hsync_o;
        for (int c = 0; c < 2 * cfg.fw; c++) begin
            @(negedge clk);
            if (hsync_o != prev_hs) rises++;
            prev_hs = hsync_o;
        end
        chk("R9 hsync frozen", rises, 0);
        chk("R9 hblank held", hblank_o, 1);

        phase = "R8 follower resume";
        for (int l = 0; l < 30; l++) begin
            if (l == 10) cfg = rand_cfg();
            ext_line(int'(cfg.fw) + int'($urandom % 8), (l % 9) == 0);
        end

        phase = "R2 back to free-run";
        ext_mode = 0;
        repeat (2000) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end
endmodule